// File: doc/BRIEF.md
# Accumulating Add/Subtract Unit

This block is the arithmetic core of a very small processor. A value taken from the shared data bus is held in an internal operand register. A short unsigned argument from the current command is then added to that held value or taken away from it, and the 8-bit result appears on output `q`. Logic outside the block decides when that result is driven back onto the bus.

The command argument is stored as one less than the step it stands for, so the adder's carry input is always 1 and the effective step is `arg + 1`. Addition and subtraction use one adder. For subtraction, the held operand is inverted bit by bit before the adder and the adder's sum is inverted after it, which gives `reg - (arg + 1)`. All results wrap modulo 2^DATA_W and never saturate. The result path has no register, so `q` follows the held value, the argument and the select within the same cycle.

Top module: `addsub_accum`

## Requirements
- R1: While `rst` is high at a rising clock edge, the operand register is cleared to 0x00. After reset, with `arg` = 0 and `neg` = 0, `q` reads 0x01.
- R2: At a rising edge where `rst` is low and `load_en` is high, the operand register takes the value on `bus_data`.
- R3: At a rising edge where `rst` and `load_en` are both low, the operand register keeps its value, whatever `bus_data` carries.
- R4: With `neg` = 0, `q` = (register + zero-extended `arg` + 1) mod 256. `arg` bits [4:0] form the low bits of the step and the upper bits are 0.
- R5: With `neg` = 1, `q` = (register - (zero-extended `arg` + 1)) mod 256.
- R6: `q` is combinational in the register, `arg` and `neg`. A change of `arg` or `neg` shows on `q` before the next clock edge.
- R7: Results wrap and do not saturate. Register 0x00 with `arg` 0 and `neg` 1 gives 0xFF. Register 0xFF with `arg` 0 and `neg` 0 gives 0x00. Register 0xF0 with `arg` 31 and `neg` 0 gives 0x10.
- R8: When `rst` and `load_en` are high at the same edge, the reset wins and the register becomes 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Value from the shared data bus |
| load_en | input | 1 | Capture `bus_data` into the operand register |
| arg | input | 5 | Command argument, encoded as step minus one |
| neg | input | 1 | 1 selects subtract, 0 selects add |
| q | output | 8 | Result of the add or subtract |

## Verification
On every clock, the assertions check three things. Reset clears the operand register, a load captures the bus value and the register holds while no load is requested. They also check each cycle that `q` matches a behavioural sum or difference for the current `neg`, which guards the gate-level inverter-adder-inverter path. Some behaviour shows only in the bench's scenarios: the wrap-around corner values, the full sweep of all 32 arguments in both directions, reset winning over a simultaneous load, and `q` moving between clock edges when only `arg` or `neg` changes.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ARG_W  = 5;
endpackage

// File: rtl/operand_reg.sv
module operand_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] stored
);
  always_ff @(posedge clk) begin
    if (rst)          stored <= '0;
    else if (load_en) stored <= d;
  end

  // R1, R8: reset clears the register even when a load is requested
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> stored == '0);
  // R2: a load captures the bus value
  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> stored == $past(d));
  // R3: the register holds when no load is requested
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(stored));
endmodule

// File: rtl/cond_invert.sv
module cond_invert #(
  parameter int unsigned W = 8
) (
  input  logic         inv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[i] ^ inv;
  end
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W-1:0] carry;

  assign carry[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sum[i] = a[i] ^ b[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  end
endmodule

// File: rtl/addsub_accum.sv
module addsub_accum
  import accum_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ARG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_data,
  input  logic          load_en,
  input  logic [AW-1:0] arg,
  input  logic          neg,
  output logic [DW-1:0] q
);
  localparam int unsigned PAD = DW - AW;
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] stored_q;
  logic [DW-1:0] ext_arg;
  logic [DW-1:0] adder_a;
  logic [DW-1:0] adder_sum;

  assign ext_arg = {{PAD{1'b0}}, arg};

  operand_reg #(.W(DW)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .d       (bus_data),
    .stored  (stored_q)
  );

  cond_invert #(.W(DW)) u_pre_inv (
    .inv  (neg),
    .din  (stored_q),
    .dout (adder_a)
  );

  ripple_adder #(.W(DW)) u_add (
    .a   (adder_a),
    .b   (ext_arg),
    .cin (1'b1),
    .sum (adder_sum)
  );

  cond_invert #(.W(DW)) u_post_inv (
    .inv  (neg),
    .din  (adder_sum),
    .dout (q)
  );

  // R4: the add path agrees with a behavioural sum
  p_add_result_r4: assert property (@(posedge clk) disable iff (rst)
    !neg |-> q == (stored_q + ext_arg + ONE));
  // R5: the subtract path agrees with a behavioural difference
  p_sub_result_r5: assert property (@(posedge clk) disable iff (rst)
    neg |-> q == (stored_q - ext_arg - ONE));
endmodule

// File: tb/tb_addsub_accum.sv
module tb_addsub_accum;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_data = '0;
  logic       load_en = 1'b0;
  logic [4:0] arg = '0;
  logic       neg = 1'b0;
  logic [7:0] q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addsub_accum dut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .load_en(load_en),
    .arg(arg), .neg(neg), .q(q)
  );

  localparam int NV = 8;
  localparam logic [7:0] V_REG [NV] = '{8'h10, 8'h10, 8'h00, 8'hFF, 8'hF0, 8'h1F, 8'h7F, 8'h80};
  localparam logic [4:0] V_ARG [NV] = '{5'd3, 5'd3, 5'd0, 5'd0, 5'd31, 5'd31, 5'd0, 5'd0};
  localparam logic       V_NEG [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [7:0] V_EXP [NV] = '{8'h14, 8'h0C, 8'hFF, 8'h00, 8'h10, 8'hFF, 8'h80, 8'h7F};

  function automatic logic [7:0] model(logic [7:0] r, logic [4:0] a, logic n);
    logic [7:0] step;
    step = {3'b000, a} + 8'd1;
    return n ? (r - step) : (r + step);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic load(logic [7:0] v);
    @(negedge clk);
    bus_data = v;
    load_en  = 1'b1;
    @(negedge clk);
    load_en  = 1'b0;
  endtask

  task automatic apply(logic [4:0] a, logic n);
    arg = a;
    neg = n;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    apply(5'd0, 1'b0);
    check("R1 reset value", q, 8'h01);

    for (int i = 0; i < NV; i++) begin
      load(V_REG[i]);
      apply(V_ARG[i], V_NEG[i]);
      check(V_NEG[i] ? "R5 table" : "R4 table", q, V_EXP[i]);
    end

    load(8'h00); apply(5'd0, 1'b1);
    check("R7 wrap below zero", q, 8'hFF);
    load(8'hFF); apply(5'd0, 1'b0);
    check("R7 wrap above max", q, 8'h00);
    load(8'hF0); apply(5'd31, 1'b0);
    check("R7 wrap full argument", q, 8'h10);

    begin
      logic [7:0] regs [3] = '{8'h00, 8'hFF, 8'h80};
      for (int r = 0; r < 3; r++) begin
        load(regs[r]);
        for (int a = 0; a < 32; a++) begin
          apply(5'(a), 1'b0);
          check("R4 sweep", q, model(regs[r], 5'(a), 1'b0));
          apply(5'(a), 1'b1);
          check("R5 sweep", q, model(regs[r], 5'(a), 1'b1));
        end
      end
    end

    load(8'h5A);
    apply(5'd0, 1'b0);
    check("R2 load", q, 8'h5B);
    @(negedge clk);
    bus_data = 8'hC3;
    repeat (3) @(negedge clk);
    apply(5'd0, 1'b0);
    check("R3 hold without load", q, 8'h5B);

    @(negedge clk);
    apply(5'd7, 1'b0);
    check("R6 arg change", q, 8'h62);
    apply(5'd7, 1'b1);
    check("R6 neg change", q, 8'h52);
    apply(5'd1, 1'b1);
    check("R6 second arg change", q, 8'h58);

    @(negedge clk);
    rst = 1'b1;
    load_en = 1'b1;
    bus_data = 8'h77;
    @(negedge clk);
    rst = 1'b0;
    load_en = 1'b0;
    apply(5'd0, 1'b0);
    check("R8 reset over load", q, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule